// File: doc/BRIEF.md
# Frame-Rate-Control Dither Colour Generator

This block turns indexed 8-bit pixels into single-bit on/off drive values for a passive LCD that has no grey levels of its own. A pixel is split into red, green and blue levels; each level is mapped by a small programmable table to one of sixteen duty-cycle codes. Each code picks a bit from a short repeating on/off pattern, so that over several frames a cell is driven for a chosen fraction of them. The bit chosen depends on a frame counter and on the pixel's horizontal position, which spreads the flicker over the panel.

Tables and pattern words are loaded through a simple register write port into shadow copies. They are copied to the working set only on a frame-start strobe, so a frame never mixes two settings. A 2-bit greyscale mode sends the low two pixel bits through the blue table and drives all three outputs with the same bit.

The control is a two-state machine. `ST_WAIT` is entered at reset. In this state pixels are dropped because no frame has begun. The transition `WAIT_TO_RUN` fires on the first `frame_start`. `ST_RUN` then holds until reset. While in `ST_RUN`, each accepted pixel gives one registered result one clock later.

Top module: `frc_dither`

## Requirements
- R1: A pixel is split 3:3:2. Bits 7:5 are the red level, bits 4:2 are the green level and bits 1:0 are the blue level.
- R2: Register map (`cfg_addr`):
  - 0 is the red table and 1 is the green table. Each holds eight 4-bit codes, with level k at bits 4k+3:4k.
  - 2 is the blue table. It holds four 4-bit codes, with level k at bits 4k+3:4k.
  - 3 is the control register. Bit 0 = 1 selects greyscale.
  - 4 to 10 are the pattern pair registers P0 to P6.
- R3: Codes 0 to 15 mean the duties 1, 6/7, 4/5, 3/4, 5/7, 2/3, 3/5, 4/7, 2/4, 3/7, 2/5, 1/3, 2/7, 1/5, 1/7 and 0. Code 0 always drives 1 and code 15 always drives 0.
- R4: For a pattern code with period p, the driven bit is bit ((n + x) mod p) of its pattern word. Here n is the number of `frame_start` strobes since reset and x is `pix_x`.
- R5: Complementary duties share a pair register; the larger duty uses bits 15:0 and the smaller one uses the inverse of those bits. The pairs are:
  - P0 holds 2/3 and 1/3.
  - P2 holds 4/5 and 1/5, and P3 holds 3/5 and 2/5.
  - P4 holds 6/7 and 1/7, P5 holds 5/7 and 2/7, and P6 holds 4/7 and 3/7.
  - P1 is the exception: 3/4 uses bits 15:0 and 2/4 uses bits 31:16, with no inversion.
- R6: After reset, the tables and patterns hold these defaults:
  - Red and green tables: 0x02468ACF.
  - Blue table: 0x04BF.
  - Control register: 0.
  - P0 to P6: 0x3, 0x00050007, 0xF, 0x15, 0x3F, 0x5B and 0x55.
- R7: A write changes the output only from the next `frame_start` on. Pixels in the current frame keep the old settings.
- R8: In greyscale mode, `pix_data[1:0]` is looked up in the blue table, and `drv_r`, `drv_g` and `drv_b` carry the same bit.
- R9: Pixels given before the first `frame_start` after reset produce no `drv_valid`.
- R10: A pixel given in the same cycle as `frame_start` is dropped.
- R11: An accepted pixel raises `drv_valid` with its three bits exactly one clock later. `drv_valid` is 0 during and right after reset.
- R12: With the default settings and a fixed x, a code of duty m/p is on for exactly m frames in every p consecutive frames.
- R13: Writes to addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle strobe that begins a frame and commits shadow settings |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 8 | Indexed pixel (3:3:2) |
| pix_x | input | XW | Horizontal position of the pixel |
| drv_valid | output | 1 | Drive bits valid |
| drv_r | output | 1 | Red drive bit |
| drv_g | output | 1 | Green drive bit |
| drv_b | output | 1 | Blue drive bit |

## Verification
The assertions assume that `frame_start` lasts one cycle and that `rst_n` is released away from a clock edge. They place no rule on when pixels or writes arrive; the block itself sorts out overlaps with the strobe. The stimulus changes inputs only on the falling edge. It keeps `frame_start` to single-cycle pulses and puts a pixel on the strobe cycle only in the test that checks that the pixel is dropped. Register writes are never given in the same cycle as a strobe, so the commit point of every setting stays clear.

// File: rtl/dith_pkg.sv
package dith_pkg;

    localparam int NPAIR = 7;
    localparam int NPER  = 4;

    localparam int ADDR_RED   = 0;
    localparam int ADDR_GRN   = 1;
    localparam int ADDR_BLU   = 2;
    localparam int ADDR_CTRL  = 3;
    localparam int ADDR_PAIR0 = 4;

    localparam logic [31:0] DEF_RG  = 32'h0246_8ACF;
    localparam logic [15:0] DEF_BLU = 16'h04BF;

    typedef enum logic [1:0] {PER3, PER4, PER5, PER7} per_e;
    typedef enum logic [1:0] {SRC_ON, SRC_OFF, SRC_PAT} src_e;

    typedef struct packed {
        src_e       src;
        logic [2:0] pair;
        logic       inv;
        logic       hi;
        per_e       per;
    } dec_t;

    function automatic int per_len(int i);
        case (i)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

    function automatic logic [31:0] def_pair(int k);
        case (k)
            0:       return 32'h0000_0003;
            1:       return 32'h0005_0007;
            2:       return 32'h0000_000F;
            3:       return 32'h0000_0015;
            4:       return 32'h0000_003F;
            5:       return 32'h0000_005B;
            default: return 32'h0000_0055;
        endcase
    endfunction

    function automatic dec_t decode(logic [3:0] c);
        dec_t d;
        d.src  = SRC_PAT;
        d.pair = 3'd0;
        d.inv  = 1'b0;
        d.hi   = 1'b0;
        d.per  = PER3;
        unique case (c)
            4'd0:  d.src = SRC_ON;
            4'd1:  begin d.pair = 3'd4; d.per = PER7; end
            4'd2:  begin d.pair = 3'd2; d.per = PER5; end
            4'd3:  begin d.pair = 3'd1; d.per = PER4; end
            4'd4:  begin d.pair = 3'd5; d.per = PER7; end
            4'd5:  begin d.pair = 3'd0; d.per = PER3; end
            4'd6:  begin d.pair = 3'd3; d.per = PER5; end
            4'd7:  begin d.pair = 3'd6; d.per = PER7; end
            4'd8:  begin d.pair = 3'd1; d.per = PER4; d.hi  = 1'b1; end
            4'd9:  begin d.pair = 3'd6; d.per = PER7; d.inv = 1'b1; end
            4'd10: begin d.pair = 3'd3; d.per = PER5; d.inv = 1'b1; end
            4'd11: begin d.pair = 3'd0; d.per = PER3; d.inv = 1'b1; end
            4'd12: begin d.pair = 3'd5; d.per = PER7; d.inv = 1'b1; end
            4'd13: begin d.pair = 3'd2; d.per = PER5; d.inv = 1'b1; end
            4'd14: begin d.pair = 3'd4; d.per = PER7; d.inv = 1'b1; end
            4'd15: d.src = SRC_OFF;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dith_cfg.sv
module dith_cfg
    import dith_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic                        commit,
    output logic [31:0]                 act_red,
    output logic [31:0]                 act_grn,
    output logic [15:0]                 act_blu,
    output logic                        act_grey,
    output logic [NPAIR-1:0][31:0]      act_pair
);

    logic [31:0]            sh_red;
    logic [31:0]            sh_grn;
    logic [15:0]            sh_blu;
    logic                   sh_grey;
    logic [NPAIR-1:0][31:0] sh_pair;

    // Shadow set: written at any time, unused addresses fall through.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_red  <= DEF_RG;
            sh_grn  <= DEF_RG;
            sh_blu  <= DEF_BLU;
            sh_grey <= 1'b0;
            for (int k = 0; k < NPAIR; k++) sh_pair[k] <= def_pair(k);
        end else if (wr_en) begin
            if (wr_addr == AW'(ADDR_RED))  sh_red  <= wr_data;
            if (wr_addr == AW'(ADDR_GRN))  sh_grn  <= wr_data;
            if (wr_addr == AW'(ADDR_BLU))  sh_blu  <= wr_data[15:0];
            if (wr_addr == AW'(ADDR_CTRL)) sh_grey <= wr_data[0];
            for (int k = 0; k < NPAIR; k++)
                if (wr_addr == AW'(ADDR_PAIR0 + k)) sh_pair[k] <= wr_data;
        end
    end

    // Working set: copied only at a frame boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_red  <= DEF_RG;
            act_grn  <= DEF_RG;
            act_blu  <= DEF_BLU;
            act_grey <= 1'b0;
            for (int k = 0; k < NPAIR; k++) act_pair[k] <= def_pair(k);
        end else if (commit) begin
            act_red  <= sh_red;
            act_grn  <= sh_grn;
            act_blu  <= sh_blu;
            act_grey <= sh_grey;
            act_pair <= sh_pair;
        end
    end

    // R7: the working set never moves inside a frame
    p_hold_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_red) && $stable(act_grn) && $stable(act_blu)
                     && $stable(act_grey) && $stable(act_pair)));

endmodule

// File: rtl/dith_phase.sv
module dith_phase
    import dith_pkg::*;
#(
    parameter int XW = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic [XW-1:0]            x,
    output logic [NPER-1:0][2:0]     ph
);

    for (genvar i = 0; i < NPER; i++) begin : g_per
        localparam int P = per_len(i);

        logic [2:0] fcnt;
        logic [2:0] xm;
        logic [3:0] sum;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   fcnt <= 3'd0;
            else if (adv) fcnt <= (fcnt == 3'(P - 1)) ? 3'd0 : fcnt + 3'd1;
        end

        always_comb begin
            xm  = 3'(x % P);
            sum = {1'b0, fcnt} + {1'b0, xm};
            ph[i] = (sum >= 4'(P)) ? 3'(sum - 4'(P)) : sum[2:0];
        end

        // R4: frame counter and phase stay inside the period
        p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fcnt < 3'(P)) && (ph[i] < 3'(P)));
    end

endmodule

// File: rtl/dith_lane.sv
module dith_lane
    import dith_pkg::*;
(
    input  logic [3:0]               code,
    input  logic [NPAIR-1:0][31:0]   pairs,
    input  logic [NPER-1:0][2:0]     ph,
    output logic                     bit_o
);

    dec_t        d;
    logic [31:0] word;
    logic [15:0] pat;
    logic        pbit;

    always_comb begin
        d     = decode(code);
        word  = pairs[d.pair];
        pat   = d.hi ? word[31:16] : word[15:0];
        pbit  = pat[ph[d.per]] ^ d.inv;
        unique case (d.src)
            SRC_ON:  bit_o = 1'b1;
            SRC_OFF: bit_o = 1'b0;
            default: bit_o = pbit;
        endcase
    end

endmodule

// File: rtl/frc_dither.sv
module frc_dither
    import dith_pkg::*;
#(
    parameter int XW = 10,
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [31:0]     cfg_wdata,
    input  logic            frame_start,
    input  logic            pix_valid,
    input  logic [7:0]      pix_data,
    input  logic [XW-1:0]   pix_x,
    output logic            drv_valid,
    output logic            drv_r,
    output logic            drv_g,
    output logic            drv_b
);

    localparam int NCH = 3;

    typedef enum logic {ST_WAIT, ST_RUN} st_e;

    st_e state_q;
    st_e state_d;

    logic [31:0]            act_red;
    logic [31:0]            act_grn;
    logic [15:0]            act_blu;
    logic                   act_grey;
    logic [NPAIR-1:0][31:0] act_pair;
    logic [NPER-1:0][2:0]   ph;

    logic [NCH-1:0][3:0]    nib;
    logic [NCH-1:0][3:0]    code;
    logic [NCH-1:0]         lane_bit;
    logic                   accept;

    dith_cfg #(.AW(AW)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .commit   (frame_start),
        .act_red  (act_red),
        .act_grn  (act_grn),
        .act_blu  (act_blu),
        .act_grey (act_grey),
        .act_pair (act_pair)
    );

    dith_phase #(.XW(XW)) i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (frame_start),
        .x     (pix_x),
        .ph    (ph)
    );

    // 3:3:2 level split through the per-channel tables
    always_comb begin
        nib[0] = act_red[{pix_data[7:5], 2'b00} +: 4];
        nib[1] = act_grn[{pix_data[4:2], 2'b00} +: 4];
        nib[2] = act_blu[{pix_data[1:0], 2'b00} +: 4];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign code[c] = act_grey ? nib[2] : nib[c];

        dith_lane i_lane (
            .code  (code[c]),
            .pairs (act_pair),
            .ph    (ph),
            .bit_o (lane_bit[c])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (frame_start) state_d = ST_RUN;   // WAIT_TO_RUN
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    assign accept = (state_q == ST_RUN) && pix_valid && !frame_start;

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_valid <= 1'b0;
            drv_r     <= 1'b0;
            drv_g     <= 1'b0;
            drv_b     <= 1'b0;
        end else begin
            drv_valid <= accept;
            drv_r     <= lane_bit[0];
            drv_g     <= lane_bit[1];
            drv_b     <= lane_bit[2];
        end
    end

    p_quiet_before_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |=> !drv_valid);

    p_strobe_drops_pixel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !drv_valid);

    p_one_cycle_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && pix_valid && !frame_start) |=> drv_valid);

    p_grey_lanes_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && act_grey) |=> (drv_r == drv_g) && (drv_g == drv_b));

    p_full_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && code[0] == 4'd0) |=> drv_r);

    p_full_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && code[0] == 4'd15) |=> !drv_r);

endmodule

// File: tb/test_frc_dither.sv
module test_frc_dither;

    localparam int XW = 10;
    localparam int AW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [AW-1:0]   cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic            frame_start = 1'b0;
    logic            pix_valid = 1'b0;
    logic [7:0]      pix_data = '0;
    logic [XW-1:0]   pix_x = '0;
    logic            drv_valid, drv_r, drv_g, drv_b;

    always #10 clk = ~clk;

    frc_dither #(.XW(XW), .AW(AW)) i_frc_dither (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_x(pix_x), .drv_valid(drv_valid),
        .drv_r(drv_r), .drv_g(drv_g), .drv_b(drv_b)
    );

    int checks = 0;
    int errors = 0;
    int nfr = 0;
    bit done = 0;

    // Bench-side settings model (shadow and active), from R2, R5, R6, R7
    logic [31:0] s_red, s_grn, m_red, m_grn;
    logic [15:0] s_blu, m_blu;
    logic        s_grey, m_grey;
    logic [31:0] s_pair [7];
    logic [31:0] m_pair [7];

    // {pix, x, expected r g b} at frame 1 with reset defaults (R1, R4, R6)
    localparam logic [20:0] VEC [10] = '{
        {8'hFF, 10'd0,    3'b111},
        {8'h00, 10'd5,    3'b000},
        {8'h29, 10'd0,    3'b010},
        {8'h72, 10'd2,    3'b001},
        {8'hBB, 10'd4,    3'b011},
        {8'hD5, 10'd10,   3'b111},
        {8'h4E, 10'd6,    3'b001},
        {8'h84, 10'd1023, 3'b110},
        {8'hE2, 10'd3,    3'b101},
        {8'h3D, 10'd9,    3'b010}
    };

    function automatic bit mbit(logic [3:0] c, int n, int x);
        int p;
        logic [15:0] w;
        bit inv;
        p = 3; w = '0; inv = 0;
        case (c)
            4'd0:  return 1'b1;
            4'd15: return 1'b0;
            4'd1:  begin p = 7; w = m_pair[4][15:0]; end
            4'd2:  begin p = 5; w = m_pair[2][15:0]; end
            4'd3:  begin p = 4; w = m_pair[1][15:0]; end
            4'd4:  begin p = 7; w = m_pair[5][15:0]; end
            4'd5:  begin p = 3; w = m_pair[0][15:0]; end
            4'd6:  begin p = 5; w = m_pair[3][15:0]; end
            4'd7:  begin p = 7; w = m_pair[6][15:0]; end
            4'd8:  begin p = 4; w = m_pair[1][31:16]; end
            4'd9:  begin p = 7; w = m_pair[6][15:0]; inv = 1; end
            4'd10: begin p = 5; w = m_pair[3][15:0]; inv = 1; end
            4'd11: begin p = 3; w = m_pair[0][15:0]; inv = 1; end
            4'd12: begin p = 7; w = m_pair[5][15:0]; inv = 1; end
            4'd13: begin p = 5; w = m_pair[2][15:0]; inv = 1; end
            default: begin p = 7; w = m_pair[4][15:0]; inv = 1; end
        endcase
        return w[(n + x) % p] ^ inv;
    endfunction

    function automatic logic [2:0] mexp(logic [7:0] px, int x);
        logic [3:0] cr, cg, cb;
        cb = m_blu[px[1:0]*4 +: 4];
        cr = m_grey ? cb : m_red[px[7:5]*4 +: 4];
        cg = m_grey ? cb : m_grn[px[4:2]*4 +: 4];
        return {mbit(cr, nfr, x), mbit(cg, nfr, x), mbit(cb, nfr, x)};
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            0: s_red = d;
            1: s_grn = d;
            2: s_blu = d[15:0];
            3: s_grey = d[0];
            4, 5, 6, 7, 8, 9, 10: s_pair[a-4] = d;
            default: ;
        endcase
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        nfr++;
        m_red = s_red; m_grn = s_grn; m_blu = s_blu; m_grey = s_grey;
        for (int k = 0; k < 7; k++) m_pair[k] = s_pair[k];
    endtask

    task automatic pix(logic [7:0] p, int x, output logic v, output logic [2:0] rgb);
        @(negedge clk);
        pix_valid = 1'b1; pix_data = p; pix_x = XW'(x);
        @(negedge clk);
        pix_valid = 1'b0;
        v = drv_valid;
        rgb = {drv_r, drv_g, drv_b};
    endtask

    task automatic pix_model(string req, logic [7:0] p, int x);
        logic v;
        logic [2:0] rgb;
        pix(p, x, v, rgb);
        check("R11 valid", {3'b0, v}, 4'd1);
        check(req, {1'b0, rgb}, {1'b0, mexp(p, x)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic v;
        logic [2:0] rgb;
        int cr, cg, cb;

        s_red = 32'h0246_8ACF; s_grn = 32'h0246_8ACF; s_blu = 16'h04BF; s_grey = 0;
        s_pair = '{32'h3, 32'h0005_0007, 32'hF, 32'h15, 32'h3F, 32'h5B, 32'h55};
        m_red = s_red; m_grn = s_grn; m_blu = s_blu; m_grey = 0;
        for (int k = 0; k < 7; k++) m_pair[k] = s_pair[k];

        repeat (3) @(negedge clk);
        check("R11 reset drv_valid", {3'b0, drv_valid}, 4'd0);
        rst_n = 1'b1;

        // R9: pixel before any frame strobe is dropped
        pix(8'hFF, 0, v, rgb);
        check("R9 no output before frame", {3'b0, v}, 4'd0);

        strobe();
        // Vector table with defaults, frame 1 (R1, R3, R4, R5, R6)
        for (int i = 0; i < 10; i++) begin
            pix(VEC[i][20:13], int'(VEC[i][12:3]), v, rgb);
            check("R11 valid", {3'b0, v}, 4'd1);
            check("R6 R4 default vector", {1'b0, rgb}, {1'b0, VEC[i][2:0]});
        end

        // R10: pixel on the strobe cycle is dropped
        @(negedge clk);
        frame_start = 1'b1; pix_valid = 1'b1; pix_data = 8'hFF;
        @(negedge clk);
        frame_start = 1'b0; pix_valid = 1'b0;
        nfr++;
        check("R10 strobe pixel dropped", {3'b0, drv_valid}, 4'd0);

        // R12: duty counts over 21 frames, fixed x
        cr = 0; cg = 0; cb = 0;
        for (int f = 0; f < 21; f++) begin
            strobe();
            pix(8'h35, 0, v, rgb);
            cr += int'(rgb[2]); cg += int'(rgb[1]); cb += int'(rgb[0]);
        end
        check("R12 red 2/7", 4'(cr), 4'd6);
        check("R12 green 5/7", 4'(cg), 4'd15);
        check("R12 blue 1/3", 4'(cb), 4'd7);

        // R7: table write is deferred to the next frame
        wr(0, 32'hFFFF_0FFF);
        pix(8'h60, 0, v, rgb);
        check("R7 old red table still active", {3'b0, rgb[2]}, 4'd0);
        strobe();
        pix(8'h60, 0, v, rgb);
        check("R2 red level 3 entry now on", {3'b0, rgb[2]}, 4'd1);
        pix(8'h40, 0, v, rgb);
        check("R2 red level 2 entry now off", {3'b0, rgb[2]}, 4'd0);

        // R5: quarter pair high half and thirds inversion
        wr(5, 32'h000A_0007);
        wr(4, 32'h0000_0005);
        pix_model("R7 patterns unchanged mid-frame", 8'h0D, 1);
        strobe();
        for (int x = 0; x < 6; x++) pix_model("R5 pair patterns", 8'h0D, x);

        // R13: writes to unused addresses change nothing
        wr(11, 32'h0);
        wr(15, 32'h0);
        strobe();
        for (int x = 0; x < 4; x++) pix_model("R13 unused address", 8'h2E, x);

        // R8: greyscale through the blue table
        wr(3, 32'h1);
        strobe();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] p;
            p = 8'((i * 37) ^ 8'hA4);
            pix(p, i, v, rgb);
            check("R8 grey lanes", {1'b0, rgb}, {1'b0, mexp(p, i)});
            check("R8 grey lanes equal", {1'b0, rgb}, {1'b0, {3{rgb[0]}}});
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule